// File: doc/BRIEF.md
# Dual-Channel Window Interrupt with Persistence Filtering

This block watches two measurement streams, a 16-bit ambient light result and an 8-bit proximity result, and turns them into sticky interrupt flags and one active-low interrupt line. Each stream has its own low and high limits. A result counts as out of range when it falls strictly below the low limit or strictly above the high limit. Each time a new result arrives, marked by its valid strobe, the block counts how many out-of-range results have arrived in a row. It raises that channel's flag once the count reaches the number that the channel's persistence code asks for.

The proximity code gives the required run length directly. The ambient light code is nonlinear: codes 1 to 3 give 1 to 3 results, and each code above 3 adds five more results, up to 60. On both channels, code 0 raises the flag on every valid result, whatever the limits are. Flags stay set until the register interface pulses the channel's clear input. The interrupt line is pulled low while any flag whose enable is set is pending. The register storage and the measurement sequencing sit outside this block.

Top module: `irq_thr_unit`

## Requirements
- R1: A result is out of range only when value < low limit or value > high limit. A value equal to either limit is in range.
- R2: On the channel's counter, an in-range valid result resets the consecutive count to zero. A new out-of-range run then has to start again from one.
- R3: On the proximity channel, with persistence code n from 1 to 15, the flag sets on the valid result that completes n consecutive out-of-range results.
- R4: On the ambient light channel, codes 1, 2 and 3 require 1, 2 and 3 consecutive out-of-range results. Code k from 4 to 15 requires 5*(k-3) results, so code 4 gives 5, code 5 gives 10 and code 15 gives 60.
- R5: Persistence code 0 sets the flag on every valid result, even when that result is in range.
- R6: The consecutive count saturates and never wraps. Once the required count has been reached, every further out-of-range result in the same run sets the flag again, including after a clear.
- R7: A flag stays set until its clear input is high at a clock edge. A clear with no qualifying result in that cycle makes the flag read 0 after that edge.
- R8: When a qualifying result and a clear land on the same channel in the same cycle, the flag is 1 after the edge.
- R9: int_n is 0 exactly when (als_flag and als_ien) or (prx_flag and prx_ien) holds. The enables never change the flags.
- R10: In a cycle with no valid strobe and no clear, a channel's flag does not change, even if its limits, value or code change.
- R11: While rst_n is low, both flags are 0 and int_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| als_valid | input | 1 | New ambient light result strobe |
| als_value | input | 16 | Ambient light result |
| als_lo | input | 16 | Ambient light low limit |
| als_hi | input | 16 | Ambient light high limit |
| als_pers | input | 4 | Ambient light persistence code (nonlinear) |
| als_clr | input | 1 | Clear ambient light flag |
| als_ien | input | 1 | Ambient light interrupt enable |
| prx_valid | input | 1 | New proximity result strobe |
| prx_value | input | 8 | Proximity result |
| prx_lo | input | 8 | Proximity low limit |
| prx_hi | input | 8 | Proximity high limit |
| prx_pers | input | 4 | Proximity persistence code (linear) |
| prx_clr | input | 1 | Clear proximity flag |
| prx_ien | input | 1 | Proximity interrupt enable |
| als_flag | output | 1 | Ambient light interrupt flag |
| prx_flag | output | 1 | Proximity interrupt flag |
| int_n | output | 1 | Active-low interrupt, models an open-drain pull-down |

## Verification
A channel's clear pulse and a qualifying result can arrive on the same edge. The set path must win, and a later lone clear must still empty the flag. The bench provokes this directly. It holds a saturated out-of-range run and applies a clear alongside a further out-of-range result, then applies a clear with no strobe. In the random phase, clears fall on about one cycle in sixteen and strobes on about half, so the two meet often on both channels. Every cycle, the flags and int_n are compared against a bench model that gives the set path priority over the clear.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;
  // Width of a persistence code
  localparam int PERS_W  = 4;
  // Largest run length the nonlinear code can ask for: 5*(15-3)
  localparam int MAX_REQ = 5 * ((1 << PERS_W) - 1 - 3);
  // Counter width derived from the largest run length
  localparam int CNT_W   = $clog2(MAX_REQ + 1);

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [PERS_W-1:0] pers_t;

  // Selects how a persistence code is turned into a run length
  typedef enum logic {
    MAP_LINEAR = 1'b0,
    MAP_SCALED = 1'b1
  } pers_map_e;
endpackage

// File: rtl/irq_thr_win.sv
module irq_thr_win #(
  parameter int W = 16
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         outside_o
);
  logic below;
  logic above;

  // Strict comparisons: values sitting on a limit are in range
  assign below     = (value_i < lo_i);
  assign above     = (value_i > hi_i);
  assign outside_o = below | above;
endmodule

// File: rtl/irq_thr_map.sv
module irq_thr_map
  import irq_thr_pkg::*;
#(
  parameter pers_map_e MODE = MAP_LINEAR
) (
  input  pers_t code_i,
  output cnt_t  req_o
);
  generate
    if (MODE == MAP_SCALED) begin : g_scaled
      cnt_t code_ext;
      cnt_t step_req;
      assign code_ext = CNT_W'(code_i);
      // Above 3, each code step adds five results
      assign step_req = CNT_W'((int'(code_ext) - 3) * 5);
      assign req_o    = (code_i < PERS_W'(4)) ? code_ext : step_req;
    end else begin : g_linear
      assign req_o = CNT_W'(code_i);
    end
  endgenerate
endmodule

// File: rtl/irq_thr_chan.sv
module irq_thr_chan
  import irq_thr_pkg::*;
#(
  parameter int        W    = 16,
  parameter pers_map_e MODE = MAP_LINEAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  pers_t        pers_i,
  input  logic         clr_i,
  output logic         flag_o
);
  localparam cnt_t CNT_MAX = '1;

  logic outside;
  cnt_t req;
  cnt_t cnt_q;
  cnt_t cnt_d;
  logic cnt_en;
  logic flag_q;
  logic flag_d;
  logic flag_en;
  logic fire;

  irq_thr_win #(.W(W)) u_win (
    .value_i   (value_i),
    .lo_i      (lo_i),
    .hi_i      (hi_i),
    .outside_o (outside)
  );

  irq_thr_map #(.MODE(MODE)) u_map (
    .code_i (pers_i),
    .req_o  (req)
  );

  // Next state of the run counter and flag
  always_comb begin
    cnt_en = valid_i;
    cnt_d  = cnt_q;
    fire   = 1'b0;
    if (valid_i) begin
      if (outside) begin
        cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + cnt_t'(1);
      end else begin
        cnt_d = '0;
      end
      fire = (pers_i == '0) || (outside && (cnt_d >= req));
    end
    flag_en = valid_i | clr_i;
    if (fire) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_thr_unit.sv
module irq_thr_unit
  import irq_thr_pkg::*;
#(
  parameter int ALS_W = 16,
  parameter int PRX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             als_valid,
  input  logic [ALS_W-1:0] als_value,
  input  logic [ALS_W-1:0] als_lo,
  input  logic [ALS_W-1:0] als_hi,
  input  logic [3:0]       als_pers,
  input  logic             als_clr,
  input  logic             als_ien,
  input  logic             prx_valid,
  input  logic [PRX_W-1:0] prx_value,
  input  logic [PRX_W-1:0] prx_lo,
  input  logic [PRX_W-1:0] prx_hi,
  input  logic [3:0]       prx_pers,
  input  logic             prx_clr,
  input  logic             prx_ien,
  output logic             als_flag,
  output logic             prx_flag,
  output logic             int_n
);
  logic als_req_int;
  logic prx_req_int;

  irq_thr_chan #(.W(ALS_W), .MODE(MAP_SCALED)) u_als (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (als_valid),
    .value_i (als_value),
    .lo_i    (als_lo),
    .hi_i    (als_hi),
    .pers_i  (als_pers),
    .clr_i   (als_clr),
    .flag_o  (als_flag)
  );

  irq_thr_chan #(.W(PRX_W), .MODE(MAP_LINEAR)) u_prx (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (prx_valid),
    .value_i (prx_value),
    .lo_i    (prx_lo),
    .hi_i    (prx_hi),
    .pers_i  (prx_pers),
    .clr_i   (prx_clr),
    .flag_o  (prx_flag)
  );

  // Enabled flags pull the shared line low
  assign als_req_int = als_flag & als_ien;
  assign prx_req_int = prx_flag & prx_ien;
  assign int_n       = ~(als_req_int | prx_req_int);
endmodule

// File: rtl/irq_thr_chk.sv
module irq_thr_chk #(
  parameter int ALS_W = 16,
  parameter int PRX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             als_valid,
  input logic [ALS_W-1:0] als_value,
  input logic [ALS_W-1:0] als_lo,
  input logic [ALS_W-1:0] als_hi,
  input logic [3:0]       als_pers,
  input logic             als_clr,
  input logic             als_ien,
  input logic             prx_valid,
  input logic [PRX_W-1:0] prx_value,
  input logic [PRX_W-1:0] prx_lo,
  input logic [PRX_W-1:0] prx_hi,
  input logic [3:0]       prx_pers,
  input logic             prx_clr,
  input logic             prx_ien,
  input logic             als_flag,
  input logic             prx_flag,
  input logic             int_n
);
  p_code0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    als_valid && als_pers == 4'd0 |=> als_flag);

  p_als_inwin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    als_valid && als_pers != 4'd0 && !als_flag &&
    als_value >= als_lo && als_value <= als_hi |=> !als_flag);

  p_prx_inwin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prx_valid && prx_pers != 4'd0 && !prx_flag &&
    prx_value >= prx_lo && prx_value <= prx_hi |=> !prx_flag);

  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prx_valid && prx_pers == 4'd1 &&
    (prx_value < prx_lo || prx_value > prx_hi) |=> prx_flag);

  p_als_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    als_clr && !als_valid |=> !als_flag);

  p_prx_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prx_clr && !prx_valid |=> !prx_flag);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prx_valid && prx_pers == 4'd0 && prx_clr |=> prx_flag);

  p_als_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !als_valid && !als_clr |=> $stable(als_flag));

  p_prx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !prx_valid && !prx_clr |=> $stable(prx_flag));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !als_ien && !prx_ien |-> int_n);

  p_als_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    als_flag && als_ien |-> !int_n);

  // R11: reset state seen on the outputs
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r11: assert (!als_flag && !prx_flag && int_n);
    end
  end
endmodule

bind irq_thr_unit irq_thr_chk #(.ALS_W(ALS_W), .PRX_W(PRX_W)) u_chk (.*);

// File: tb/irq_thr_unit_bench.sv
`timescale 1ns/1ps
module irq_thr_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        als_valid;
  logic [15:0] als_value;
  logic [15:0] als_lo;
  logic [15:0] als_hi;
  logic [3:0]  als_pers;
  logic        als_clr;
  logic        als_ien;
  logic        prx_valid;
  logic [7:0]  prx_value;
  logic [7:0]  prx_lo;
  logic [7:0]  prx_hi;
  logic [3:0]  prx_pers;
  logic        prx_clr;
  logic        prx_ien;
  logic        als_flag;
  logic        prx_flag;
  logic        int_n;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench model state
  int   m_acnt = 0;
  int   m_pcnt = 0;
  logic m_af   = 1'b0;
  logic m_pf   = 1'b0;

  irq_thr_unit u_irq_thr_unit (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int als_req(input int code);
    return (code <= 3) ? code : 5 * (code - 3);
  endfunction

  function automatic logic outside(input int v, input int lo, input int hi);
    return (v < lo) || (v > hi);
  endfunction

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic model_step();
    logic o;
    logic fire;
    if (als_valid) begin
      o      = outside(int'(als_value), int'(als_lo), int'(als_hi));
      m_acnt = o ? ((m_acnt == 63) ? 63 : m_acnt + 1) : 0;
      fire   = (als_pers == 0) || (o && m_acnt >= als_req(int'(als_pers)));
    end else begin
      fire = 1'b0;
    end
    m_af = fire ? 1'b1 : (als_clr ? 1'b0 : m_af);
    if (prx_valid) begin
      o      = outside(int'(prx_value), int'(prx_lo), int'(prx_hi));
      m_pcnt = o ? ((m_pcnt == 63) ? 63 : m_pcnt + 1) : 0;
      fire   = (prx_pers == 0) || (o && m_pcnt >= int'(prx_pers));
    end else begin
      fire = 1'b0;
    end
    m_pf = fire ? 1'b1 : (prx_clr ? 1'b0 : m_pf);
  endtask

  // One clock: advance model, sample at the falling edge, drop strobes
  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    chk(tag, "als_flag", als_flag, m_af);
    chk(tag, "prx_flag", prx_flag, m_pf);
    chk(tag, "int_n", int_n, ~((m_af & als_ien) | (m_pf & prx_ien)));
    als_valid = 1'b0;
    prx_valid = 1'b0;
    als_clr   = 1'b0;
    prx_clr   = 1'b0;
  endtask

  task automatic als_res(input int v, input string tag);
    als_valid = 1'b1;
    als_value = 16'(v);
    tick(tag);
  endtask

  task automatic prx_res(input int v, input string tag);
    prx_valid = 1'b1;
    prx_value = 8'(v);
    tick(tag);
  endtask

  task automatic clear_both(input string tag);
    als_clr = 1'b1;
    prx_clr = 1'b1;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    rst_n = 1'b0;
    als_valid = 1'b0; als_value = '0; als_lo = 16'd100; als_hi = 16'd200;
    als_pers = 4'd1; als_clr = 1'b0; als_ien = 1'b1;
    prx_valid = 1'b0; prx_value = '0; prx_lo = 8'd50; prx_hi = 8'd150;
    prx_pers = 4'd1; prx_clr = 1'b0; prx_ien = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "als_flag", als_flag, 1'b0);
    chk("R11", "prx_flag", prx_flag, 1'b0);
    chk("R11", "int_n", int_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: values on the limits are in range
    als_res(100, "R1"); als_res(200, "R1");
    prx_res(50, "R1");  prx_res(150, "R1");
    als_res(99, "R1");
    clear_both("R7");
    als_res(201, "R1");
    prx_res(151, "R1");
    clear_both("R7");

    // R5: code 0 fires on an in-range result
    als_pers = 4'd0; prx_pers = 4'd0;
    als_res(150, "R5");
    prx_res(100, "R5");
    // R7: lone clear
    clear_both("R7");

    // R4: code 4 -> 5 results, code 5 -> 10, code 15 -> 60
    als_res(150, "R4");
    als_pers = 4'd4;
    for (int i = 0; i < 5; i++) als_res(20, "R4");
    clear_both("R7");
    als_res(150, "R2");
    als_pers = 4'd5;
    for (int i = 0; i < 10; i++) als_res(20, "R4");
    clear_both("R7");
    als_res(150, "R2");
    als_pers = 4'd15;
    for (int i = 0; i < 60; i++) als_res(500, "R4");
    clear_both("R7");
    als_res(150, "R2");
    als_pers = 4'd3;
    for (int i = 0; i < 3; i++) als_res(20, "R4");
    clear_both("R7");

    // R3: proximity code 3 and 15
    prx_res(100, "R2");
    prx_pers = 4'd3;
    for (int i = 0; i < 3; i++) prx_res(10, "R3");
    clear_both("R7");
    prx_res(100, "R2");
    prx_pers = 4'd15;
    for (int i = 0; i < 15; i++) prx_res(200, "R3");
    clear_both("R7");

    // R2: an in-range result breaks the run
    prx_res(100, "R2");
    prx_pers = 4'd2;
    prx_res(10, "R2"); prx_res(100, "R2"); prx_res(10, "R2");
    prx_res(10, "R2");
    clear_both("R7");

    // R6: long run saturates, no wrap, refires after clear
    prx_pers = 4'd15; als_pers = 4'd1;
    for (int i = 0; i < 70; i++) begin
      als_valid = 1'b1; als_value = 16'd900;
      prx_valid = 1'b1; prx_value = 8'd250;
      tick("R6");
    end
    clear_both("R7");
    als_valid = 1'b1; als_value = 16'd900;
    prx_valid = 1'b1; prx_value = 8'd250;
    tick("R6");

    // R8: qualifying result and clear in the same cycle
    als_valid = 1'b1; als_value = 16'd900; als_clr = 1'b1;
    prx_valid = 1'b1; prx_value = 8'd250; prx_clr = 1'b1;
    tick("R8");

    // R10: no strobe, limits and codes moved, flags hold
    als_lo = 16'd0; als_hi = 16'hFFFF; prx_lo = 8'd0; prx_hi = 8'hFF;
    als_pers = 4'd7; prx_pers = 4'd9;
    tick("R10");
    tick("R10");

    // R9: enable combinations with both flags set
    als_ien = 1'b0; prx_ien = 1'b0; tick("R9");
    als_ien = 1'b1; prx_ien = 1'b0; tick("R9");
    als_ien = 1'b0; prx_ien = 1'b1; tick("R9");
    als_clr = 1'b1; tick("R9");
    prx_clr = 1'b1; tick("R9");
    als_ien = 1'b1;

    // Random phase: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 0) begin
        als_pers = 4'($urandom_range(0, 15));
        prx_pers = 4'($urandom_range(0, 15));
        als_lo = 16'($urandom_range(0, 120));
        als_hi = als_lo + 16'($urandom_range(0, 120));
        prx_lo = 8'($urandom_range(0, 100));
        prx_hi = prx_lo + 8'($urandom_range(0, 100));
        als_ien = 1'($urandom_range(0, 1));
        prx_ien = 1'($urandom_range(0, 1));
      end
      als_valid = ($urandom_range(0, 1) == 1);
      prx_valid = ($urandom_range(0, 1) == 1);
      als_value = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 250))
                                              : 16'($urandom_range(230, 400));
      prx_value = 8'($urandom_range(0, 255));
      als_clr   = ($urandom_range(0, 15) == 0);
      prx_clr   = ($urandom_range(0, 15) == 0);
      tick("RND");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule